// File: doc/BRIEF.md
# Pipelined Partial-Product Tree Multiplier

This block multiplies two unsigned operands and returns the full-width product. Each multiplier bit gates a copy of the multiplicand, which gives one partial product per multiplier bit. A balanced binary tree of adders then folds these partial products together. Every tree level ends in a register, so the datapath accepts a new operand pair on every clock and needs no stall or handshake.

At the first tree level, each pair of neighbouring partial products is summed with the higher one shifted left by one place. Each level after that sums neighbouring results with the higher one shifted by twice the previous amount: 2, then 4, then 8. With the default 16-bit operands the tree has four levels, and the product therefore comes out four clocks after the operands. A valid flag travels beside the data in a shift register of the same depth, so every product is tagged with its own valid. A synchronous reset clears only that valid pipeline. The data registers keep whatever they hold, because their contents matter only while the matching valid is high.

Top module: `pp_tree_mul`

## Requirements
- R1: The operands `in_a` and `in_b` are 16-bit unsigned values. The 32-bit `out_product` equals their exact arithmetic product for all operand values; for example, 0xFFFF times 0xFFFF gives 0xFFFE0001.
- R2: An operand pair sampled with `in_valid` high on a rising edge appears on `out_product`, with `out_valid` high, after the fourth rising edge that follows.
- R3: Operand pairs presented on consecutive cycles all produce correct products on consecutive cycles, one product per clock.
- R4: `out_valid` equals `in_valid` delayed by four cycles. Gaps in the input stream appear unchanged in the output stream.
- R5: While `rst` is high on a rising edge, every stage of the valid pipeline clears. Operands that are in flight, or that are presented while reset is high, never raise `out_valid`, and `out_valid` is low from the first edge of reset onwards.
- R6: Partial product i is `in_a` ANDed with bit i of `in_b`. A multiplier with only bit i set therefore returns `in_a` shifted left by i, for every i from 0 to 15.
- R7: A zero in either operand gives a product of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Marks `in_a` and `in_b` as a pair to multiply |
| in_a | input | 16 | Multiplicand, unsigned |
| in_b | input | 16 | Multiplier, unsigned; each bit gates one partial product |
| out_valid | output | 1 | High when `out_product` holds a result |
| out_product | output | 32 | Unsigned product, registered |

## Verification
On every cycle, the assertions compare each product flagged valid against the operands seen four cycles earlier. They also tie `out_valid` to the delayed `in_valid` once the pipeline has filled after a reset, and they check that the valid pipeline is empty right after a reset edge. The bench scenarios are needed to show the rest: that the tree stays exact at the carry-heavy all-ones corner and at every single-bit multiplier, that back-to-back and gapped streams keep their order, and that work caught in flight by a mid-stream reset is dropped.

// File: rtl/pp_tree_mul_pkg.sv
package pp_tree_mul_pkg;

  // Width of one sum at tree level l. Level 0 holds the raw partial products.
  function automatic int lvl_w(input int a_w, input int l);
    return (l == 0) ? a_w : a_w + (1 << l);
  endfunction

  // Number of sums at tree level l.
  function automatic int lvl_n(input int b_w, input int l);
    return b_w >> l;
  endfunction

  // Bit offset of level l inside the flat tree bus.
  function automatic int lvl_off(input int a_w, input int b_w, input int l);
    int acc;
    acc = 0;
    for (int k = 0; k < l; k++) acc += lvl_n(b_w, k) * lvl_w(a_w, k);
    return acc;
  endfunction

endpackage

// File: rtl/pp_gen.sv
module pp_gen #(
  parameter int A_W = 16,
  parameter int B_W = 16
) (
  input  logic [A_W-1:0]     mcand,
  input  logic [B_W-1:0]     mplier,
  output logic [B_W*A_W-1:0] pp_bus
);

  // One gated copy of the multiplicand per multiplier bit.
  for (genvar i = 0; i < B_W; i++) begin : g_pp
    assign pp_bus[i*A_W +: A_W] = mcand & {A_W{mplier[i]}};
  end

endmodule

// File: rtl/pp_tree_stage.sv
module pp_tree_stage #(
  parameter int N_OUT = 8,
  parameter int IN_W  = 16,
  parameter int OUT_W = 18,
  parameter int SHIFT = 1
) (
  input  logic                   clk,
  input  logic [2*N_OUT*IN_W-1:0] in_bus,
  output logic [N_OUT*OUT_W-1:0]  out_bus
);

  logic [OUT_W-1:0] sum_d [N_OUT];
  logic [OUT_W-1:0] sum_q [N_OUT];

  // Pairwise sums; the upper element of each pair carries the higher weight.
  always_comb begin
    for (int k = 0; k < N_OUT; k++) begin
      sum_d[k] = OUT_W'(in_bus[(2*k)*IN_W +: IN_W])
               + (OUT_W'(in_bus[(2*k+1)*IN_W +: IN_W]) << SHIFT);
    end
  end

  // Data registers carry no reset; validity travels in a separate pipeline.
  always_ff @(posedge clk) begin
    for (int k = 0; k < N_OUT; k++) sum_q[k] <= sum_d[k];
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    assign out_bus[k*OUT_W +: OUT_W] = sum_q[k];
  end

endmodule

// File: rtl/valid_pipe.sv
module valid_pipe #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic vin,
  output logic vout
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] sr;
  logic [CNT_W-1:0] fill_cnt;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[DEPTH-2:0], vin};
  end

  assign vout = sr[DEPTH-1];

  // Cycles since reset, saturating at DEPTH; used only by the checks below.
  always_ff @(posedge clk) begin
    if (rst)                        fill_cnt <= '0;
    else if (fill_cnt != CNT_W'(DEPTH)) fill_cnt <= fill_cnt + 1'b1;
  end

  AST_RESET_EMPTIES: assert property (@(posedge clk) $past(rst) |-> !vout) // R5
    else $error("valid pipeline not empty after reset");

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
    (fill_cnt == CNT_W'(DEPTH)) |-> (vout == $past(vin, DEPTH))) // R4
    else $error("valid not delayed by pipeline depth");

  AST_VALID_SOURCE: assert property (@(posedge clk) disable iff (rst)
    vout |-> $past(vin, DEPTH)) // R2
    else $error("valid raised without matching input");

endmodule

// File: rtl/pp_tree_mul.sv
module pp_tree_mul
  import pp_tree_mul_pkg::*;
#(
  parameter int A_W = 16,
  parameter int B_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [A_W-1:0]   in_a,
  input  logic [B_W-1:0]   in_b,
  output logic             out_valid,
  output logic [A_W+B_W-1:0] out_product
);

  localparam int LEVELS = $clog2(B_W);
  localparam int P_W    = A_W + B_W;
  localparam int TOT_W  = lvl_off(A_W, B_W, LEVELS + 1);
  localparam int TOP_OFF = lvl_off(A_W, B_W, LEVELS);

  logic [TOT_W-1:0] tree_bus;

  pp_gen #(.A_W(A_W), .B_W(B_W)) u_pp (
    .mcand  (in_a),
    .mplier (in_b),
    .pp_bus (tree_bus[0 +: B_W*A_W])
  );

  for (genvar l = 1; l <= LEVELS; l++) begin : g_lvl
    localparam int N_OUT = lvl_n(B_W, l);
    localparam int IN_W  = lvl_w(A_W, l - 1);
    localparam int OUT_W = lvl_w(A_W, l);
    localparam int I_OFF = lvl_off(A_W, B_W, l - 1);
    localparam int O_OFF = lvl_off(A_W, B_W, l);

    pp_tree_stage #(
      .N_OUT (N_OUT),
      .IN_W  (IN_W),
      .OUT_W (OUT_W),
      .SHIFT (1 << (l - 1))
    ) u_stage (
      .clk     (clk),
      .in_bus  (tree_bus[I_OFF +: 2*N_OUT*IN_W]),
      .out_bus (tree_bus[O_OFF +: N_OUT*OUT_W])
    );
  end

  valid_pipe #(.DEPTH(LEVELS)) u_vld (
    .clk  (clk),
    .rst  (rst),
    .vin  (in_valid),
    .vout (out_valid)
  );

  assign out_product = tree_bus[TOP_OFF +: P_W];

  AST_PRODUCT_EXACT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_product == (P_W'($past(in_a, LEVELS)) * P_W'($past(in_b, LEVELS))))) // R1
    else $error("tree product differs from operands");

endmodule

// File: tb/tb_pp_tree_mul.sv
module tb_pp_tree_mul;

  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_a = '0;
  logic [15:0] in_b = '0;
  logic        out_valid;
  logic [31:0] out_product;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  bit          h_v   [LAT];
  logic [15:0] h_a   [LAT];
  logic [15:0] h_b   [LAT];
  string       h_tag [LAT];

  always #4 clk = ~clk;

  pp_tree_mul dut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_product(out_product)
  );

  function automatic logic [31:0] ref_mul(input logic [15:0] a, input logic [15:0] b);
    return 32'(a) * 32'(b);
  endfunction

  task automatic check_out();
    checks++;
    if (out_valid !== h_v[LAT-1]) begin
      errors++;
      $display("FAIL R4 (%s): out_valid=%0b expected=%0b", h_tag[LAT-1], out_valid, h_v[LAT-1]);
    end
    if (h_v[LAT-1] && out_valid === 1'b1) begin
      checks++;
      if (out_product !== ref_mul(h_a[LAT-1], h_b[LAT-1])) begin
        errors++;
        $display("FAIL %s: product=%h expected=%h (a=%h b=%h)", h_tag[LAT-1], out_product,
                 ref_mul(h_a[LAT-1], h_b[LAT-1]), h_a[LAT-1], h_b[LAT-1]);
      end
    end
  endtask

  // One cycle: check the result due now, then drive the next inputs.
  task automatic step(input bit r, input bit v, input logic [15:0] a,
                      input logic [15:0] b, input string tag);
    @(negedge clk);
    check_out();
    for (int k = LAT - 1; k > 0; k--) begin
      h_v[k] = h_v[k-1]; h_a[k] = h_a[k-1]; h_b[k] = h_b[k-1]; h_tag[k] = h_tag[k-1];
    end
    if (r) for (int k = 0; k < LAT; k++) h_v[k] = 1'b0;
    h_v[0] = v && !r; h_a[0] = a; h_b[0] = b; h_tag[0] = tag;
    rst = r; in_valid = v; in_a = a; in_b = b;
  endtask

  initial begin
    for (int k = 0; k < LAT; k++) begin
      h_v[k] = 1'b0; h_a[k] = '0; h_b[k] = '0; h_tag[k] = "R5 reset";
    end
    void'($urandom(32'd1357));
    // Reset with in_valid high: nothing may emerge (R5)
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 16'h1234, 16'h5678, "R5");
    // Corner cases (R1, R7)
    step(1'b0, 1'b1, 16'hFFFF, 16'hFFFF, "R1 all-ones");
    step(1'b0, 1'b1, 16'h0000, 16'hFFFF, "R7 zero a");
    step(1'b0, 1'b1, 16'hFFFF, 16'h0000, "R7 zero b");
    step(1'b0, 1'b1, 16'h8000, 16'h8000, "R1 msb");
    step(1'b0, 1'b1, 16'hAAAA, 16'h5555, "R1 alternating");
    // Single-bit multipliers (R6)
    for (int i = 0; i < 16; i++)
      step(1'b0, 1'b1, 16'($urandom) | 16'h8001, 16'(1) << i, "R6 single bit");
    // Back-to-back random stream (R3)
    for (int i = 0; i < 200; i++)
      step(1'b0, 1'b1, 16'($urandom), 16'($urandom), "R3 stream");
    // Gapped stream (R2, R4)
    for (int i = 0; i < 200; i++)
      step(1'b0, 1'($urandom), 16'($urandom), 16'($urandom), "R2 gapped");
    // Reset caught mid-stream drops in-flight work (R5)
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 16'($urandom), 16'($urandom), "R5 pre");
    step(1'b1, 1'b1, 16'hFFFF, 16'hFFFF, "R5");
    step(1'b0, 1'b1, 16'hFFFF, 16'hFFFE, "R1 after reset");
    for (int i = 0; i < LAT + 2; i++) step(1'b0, 1'b0, '0, '0, "R4 drain");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule